// File: doc/BRIEF.md
# Maskable Interrupt Status and Enable Registers

This block holds two 32-bit host-visible registers: an interrupt status register that latches event pulses from up to 31 sources, and an enable (mask) register that selects which of those sources count toward a summary bit. The summary bit occupies data bit 31 of the status word. Data bits 30 down to 0 hold the sources. The block drives one interrupt line toward the host. The line is raised when the summary bit is set and the enable bit in the same position of the mask word is also set.

The host reaches both registers through a plain single-cycle register bus with separate write and read strobes. The status register is at offset 0Ch and the mask register at offset 10h. Software normally services an interrupt by writing ones to the status bits it has handled, which clears them. A diagnostic mode input turns the status register into an ordinary read/write register, including the summary bit. This lets a test program force any pattern.

The summary bit is never allowed to disagree with a pending enabled source. Any write that tries to drop it while an enabled source is still set is overridden in the same clock edge.

Top module: `irq_stat_mask`

## Requirements
- R1: The mask register at offset 10h is fully writable, reads back what was written, and resets to 0000_0000h.
- R2: The status register resets to 8000_0000h: summary bit (data bit 31) set, source bits 30..0 clear. While the diagnostic input is 1 and no event or write occurs, this value is held.
- R3: A one-cycle pulse on event input i (i = 0..30) sets status bit i at the next clock edge, and the bit stays set until the host clears or overwrites it.
- R4: With the diagnostic input at 0, a write to offset 0Ch clears each source bit whose write-data bit is 1 and leaves the others unchanged. Write-data bit 31 has no effect on the summary bit.
- R5: With the diagnostic input at 1, a write to offset 0Ch loads all 32 bits from the write data, summary bit included, subject to R8 and R10.
- R6: With the diagnostic input at 0, the summary bit equals the OR over i = 0..30 of (status bit i AND mask bit i). It is updated at the same edge as the source and mask bits it depends on.
- R7: The interrupt output equals the summary bit AND mask bit 31 at all times.
- R8: When an event pulse and a status write (clear or load) reach the same bit in the same cycle, the event wins and the bit is 1 after the edge.
- R9: A read strobe returns, one clock later on the read-data port, the value the addressed register held before that edge. Offsets other than 0Ch and 10h read as zero. Read data holds its value while no read strobe is given.
- R10: A diagnostic write of 0 to the summary bit while any enabled source bit will be set after the edge leaves the summary bit reading 1.
- R11: A mask write that enables an already-set source raises the summary bit at that same edge. One that disables the last enabled source drops it when the diagnostic input is 0.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all registers on the rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| regRW | input | 1 | Diagnostic mode: 1 makes the status register plain read/write |
| evtPulse | input | 31 | Event pulses; bit i sets status bit i |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe |
| addr | input | 8 | Host byte offset |
| wrData | input | 32 | Host write data |
| rdData | output | 32 | Registered host read data |
| irq | output | 1 | Interrupt line to the host |

## Verification
The interesting collisions are an event pulse landing on a source bit in the same cycle a host write clears or reloads it, and a mask write landing in the same cycle a source first sets. Both are provoked once by hand with known expected words: a clear of bit 2 together with a pulse on bit 2, and a diagnostic write of a zero summary while an enabled source stays set. Both are then provoked many times by a random mix of sparse pulses, writes and reads. Every cycle, the read data and interrupt line are compared with a behavioural model of the two registers kept in the bench.

// File: rtl/irq_stat_mask_pkg.sv
package irq_stat_mask_pkg;

  // Strobes from the address decode to the register datapath.
  typedef struct packed {
    logic statWr;  // host write hits the status register
    logic maskWr;  // host write hits the mask register
    logic statRd;  // host read selects the status register
    logic maskRd;  // host read selects the mask register
    logic anyRd;   // a read is in progress (unmapped reads return zero)
    logic diag;    // status register behaves as plain read/write
  } regStrobe_t;

endpackage

// File: rtl/irq_stat_mask_ctl.sv
module irq_stat_mask_ctl
  import irq_stat_mask_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h0C,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'h10
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              regRW,
  output regStrobe_t        strb
);

  logic hitStat;
  logic hitMask;

  assign hitStat = (addr == STAT_OFS);
  assign hitMask = (addr == MASK_OFS);

  always_comb begin
    strb        = '0;
    strb.statWr = wrEn && hitStat;
    strb.maskWr = wrEn && hitMask;
    strb.statRd = rdEn && hitStat;
    strb.maskRd = rdEn && hitMask;
    strb.anyRd  = rdEn;
    strb.diag   = regRW;
  end

endmodule

// File: rtl/irq_stat_mask_dp.sv
module irq_stat_mask_dp
  import irq_stat_mask_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strb,
  input  logic [DATA_W-2:0]  evtPulse,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq,
  output logic [DATA_W-1:0]  statusVal,
  output logic [DATA_W-1:0]  maskVal
);

  localparam int SRC_W   = DATA_W - 1;
  localparam int SUM_BIT = DATA_W - 1;

  logic [SRC_W-1:0]  srcQ, srcNext;
  logic              sumQ, sumNext;
  logic [DATA_W-1:0] maskQ, maskNext;
  logic              anyMasked;
  logic              diagStatWr;

  assign diagStatWr = strb.statWr && strb.diag;

  // Mask register next state.
  always_comb begin
    maskNext = maskQ;
    if (strb.maskWr) maskNext = wrData;
  end

  // Per-source next state: event pulse dominates any host write.
  for (genvar i = 0; i < SRC_W; i++) begin : gSrc
    logic hostVal;
    assign hostVal    = strb.diag ? wrData[i] : (srcQ[i] & ~wrData[i]);
    assign srcNext[i] = evtPulse[i] | (strb.statWr ? hostVal : srcQ[i]);
  end

  // Summary uses next-state sources and mask so it never lags them.
  assign anyMasked = |(srcNext & maskNext[SRC_W-1:0]);

  always_comb begin
    if (diagStatWr)       sumNext = wrData[SUM_BIT] | anyMasked;
    else if (anyMasked)   sumNext = 1'b1;
    else if (!strb.diag)  sumNext = 1'b0;
    else                  sumNext = sumQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ  <= '0;
      sumQ  <= 1'b1;
      maskQ <= '0;
    end else begin
      srcQ  <= srcNext;
      sumQ  <= sumNext;
      maskQ <= maskNext;
    end
  end

  assign statusVal = {sumQ, srcQ};
  assign maskVal   = maskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.anyRd) begin
      if (strb.statRd)      rdData <= statusVal;
      else if (strb.maskRd) rdData <= maskQ;
      else                  rdData <= '0;
    end
  end

  assign irq = sumQ & maskQ[SUM_BIT];

endmodule

// File: rtl/irq_stat_mask.sv
module irq_stat_mask
  import irq_stat_mask_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h0C,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regRW,
  input  logic [DATA_W-2:0] evtPulse,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  regStrobe_t        strb;
  logic [DATA_W-1:0] statusVal;
  logic [DATA_W-1:0] maskVal;

  irq_stat_mask_ctl #(
    .ADDR_W  (ADDR_W),
    .STAT_OFS(STAT_OFS),
    .MASK_OFS(MASK_OFS)
  ) uCtl (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .regRW(regRW),
    .strb (strb)
  );

  irq_stat_mask_dp #(
    .DATA_W(DATA_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .evtPulse (evtPulse),
    .wrData   (wrData),
    .rdData   (rdData),
    .irq      (irq),
    .statusVal(statusVal),
    .maskVal  (maskVal)
  );

endmodule

// File: rtl/irq_stat_mask_chk.sv
module irq_stat_mask_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h0C,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'h10
) (
  input logic              clk,
  input logic              rstN,
  input logic              regRW,
  input logic [DATA_W-2:0] evtPulse,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              irq,
  input logic [DATA_W-1:0] statusVal,
  input logic [DATA_W-1:0] maskVal
);

  localparam int SRC_W   = DATA_W - 1;
  localparam int SUM_BIT = DATA_W - 1;

  AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == MASK_OFS) |=> (maskVal == $past(wrData))); // R1

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (|evtPulse) |=> ((statusVal[SRC_W-1:0] & $past(evtPulse)) == $past(evtPulse))); // R8

  AST_CLEAR_NEVER_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (!regRW && wrEn && addr == STAT_OFS) |=>
      ((statusVal[SRC_W-1:0] & ~$past(statusVal[SRC_W-1:0]) & ~$past(evtPulse)) == '0)); // R4

  AST_SUM_COVERS: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusVal[SRC_W-1:0] & maskVal[SRC_W-1:0])) |-> statusVal[SUM_BIT]); // R10

  AST_SUM_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    !regRW |=> (statusVal[SUM_BIT] == |(statusVal[SRC_W-1:0] & maskVal[SRC_W-1:0]))); // R6

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (maskVal[SUM_BIT] && statusVal[SUM_BIT])); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr != STAT_OFS && addr != MASK_OFS) |=> (rdData == '0)); // R9

  AST_RD_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEn && $past(rstN)) |=> $stable(rdData)); // R9

endmodule

bind irq_stat_mask irq_stat_mask_chk #(
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .STAT_OFS(STAT_OFS),
  .MASK_OFS(MASK_OFS)
) uChk (.*);

// File: tb/irq_stat_mask_test.sv
`timescale 1ns/1ps
module irq_stat_mask_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regRW = 1'b1;
  logic [30:0] evtPulse = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  bit running = 0;

  always #10 clk = ~clk;  // 50 MHz

  irq_stat_mask uut (
    .clk(clk), .rstN(rstN), .regRW(regRW), .evtPulse(evtPulse),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irq(irq)
  );

  // Behavioural reference of the two registers and the read port.
  logic [31:0] mStat, mMask, mRd;
  always @(posedge clk) begin
    logic [30:0] nSrc;
    logic [31:0] nMask;
    logic        nSum, anyM, stW;
    if (!rstN) begin
      mStat = 32'h8000_0000;
      mMask = '0;
      mRd   = '0;
    end else begin
      if (rdEn) mRd = (addr == 8'h0C) ? mStat : (addr == 8'h10) ? mMask : 32'h0;
      stW   = wrEn && addr == 8'h0C;
      nMask = (wrEn && addr == 8'h10) ? wrData : mMask;
      nSrc  = mStat[30:0];
      if (stW) nSrc = regRW ? wrData[30:0] : (nSrc & ~wrData[30:0]);
      nSrc  = nSrc | evtPulse;
      anyM  = (nSrc & nMask[30:0]) != 0;
      if (stW && regRW) nSum = wrData[31] | anyM;
      else if (anyM)    nSum = 1'b1;
      else if (!regRW)  nSum = 1'b0;
      else              nSum = mStat[31];
      mStat = {nSum, nSrc};
      mMask = nMask;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      chk("R9", rdData, mRd);
      chk("R7", {31'b0, irq}, {31'b0, mStat[31] & mMask[31]});
    end
  end

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic pulse(input logic [30:0] b);
    evtPulse = b;
    @(negedge clk);
    evtPulse = '0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    chk("R9 reset rdData", rdData, 32'h0);
    chk("R7 reset irq", {31'b0, irq}, 32'h0);
    rstN = 1'b1;
    running = 1;
    busRd(8'h0C, v); chk("R2 status reset", v, 32'h8000_0000);
    busRd(8'h10, v); chk("R1 mask reset", v, 32'h0);
    regRW = 1'b0;
    @(negedge clk);
    busRd(8'h0C, v); chk("R6 summary recomputed", v, 32'h0);

    busWr(8'h10, 32'h8000_0005);
    busRd(8'h10, v); chk("R1 mask readback", v, 32'h8000_0005);

    pulse(31'h2);
    busRd(8'h0C, v); chk("R3 unmasked event", v, 32'h0000_0002);
    chk("R7 irq low", {31'b0, irq}, 32'h0);
    pulse(31'h1);
    busRd(8'h0C, v); chk("R6 masked event", v, 32'h8000_0003);
    chk("R7 irq high", {31'b0, irq}, 32'h1);

    busWr(8'h0C, 32'h8000_0001);
    busRd(8'h0C, v); chk("R4 clear, summary unwritable", v, 32'h0000_0002);

    evtPulse = 31'h4;
    busWr(8'h0C, 32'h0000_0004);
    evtPulse = '0;
    busRd(8'h0C, v); chk("R8 event beats clear", v, 32'h8000_0006);

    regRW = 1'b1;
    busWr(8'h0C, 32'h0000_0004);
    busRd(8'h0C, v); chk("R10 summary forced back", v, 32'h8000_0004);
    busWr(8'h0C, 32'h8000_0000);
    busRd(8'h0C, v); chk("R5 diag load summary", v, 32'h8000_0000);
    chk("R7 irq from diag summary", {31'b0, irq}, 32'h1);
    busWr(8'h0C, 32'h4000_0010);
    busRd(8'h0C, v); chk("R5 diag load sources", v, 32'h4000_0010);

    regRW = 1'b0;
    @(negedge clk);
    busWr(8'h10, 32'h8000_0010);
    busRd(8'h0C, v); chk("R11 unmask raises summary", v, 32'hC000_0010);
    busWr(8'h10, 32'h8000_0000);
    busRd(8'h0C, v); chk("R11 mask drops summary", v, 32'h4000_0010);

    busRd(8'h14, v); chk("R9 unmapped read", v, 32'h0);
    busRd(8'h10, v);
    repeat (3) @(negedge clk);
    chk("R9 read data holds", rdData, 32'h8000_0000);

    for (int n = 0; n < 4000; n++) begin
      evtPulse = (($urandom % 6) == 0) ? (31'h1 << ($urandom % 31)) : 31'h0;
      wrEn   = (($urandom % 4) == 0);
      rdEn   = (($urandom % 2) == 0);
      case ($urandom % 5)
        0, 1:    addr = 8'h0C;
        2, 3:    addr = 8'h10;
        default: addr = 8'h14;
      endcase
      wrData = $urandom;
      if (($urandom % 40) == 0) regRW = ~regRW;
      @(negedge clk);
    end
    wrEn = 1'b0; rdEn = 1'b0; evtPulse = '0;
    @(negedge clk);

    running = 0;
    finished = 1;
    summary();
    $finish;
  end

endmodule